// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block watches the transmit and receive error counters of a CAN controller, together with single-cycle pulses that report each kind of protocol error. From these it keeps a status register and a set of interrupt flags. The status register holds sticky flags, one per error kind. It also holds one live bit for each of the warning, passive and bus-off levels, and two bits that mark which side (transmit or receive) is the one at fault. When the level moves upward, an interrupt flag for the new level is set. Each flag reaches the single interrupt line only where the mask register enables it.

Software reaches the block through a small synchronous register port. There is one write strobe, and reads return data one cycle after the address. The counter update rules live outside this block: it only reads the counter values.

Top module: `can_fault_tracker`

## Requirements
- R1: While reset is high, reg_rdata and irq are 0. After reset the interrupt flag register (address 1) reads 0 and the mask register (address 2) reads 0x700.
- R2: The level is taken from the counter values of the previous cycle. Bus-off applies when tx_err_cnt > 255 and overrides the other levels. Otherwise passive applies when either counter is 128 or more, and warning applies when either counter is 96 or more. The level is shown in status (address 0) as bit 16 for warning, bit 17 for passive and bit 18 for bus-off, with at most one of these set.
- R3: A pulse on err_evt[i] sets status bit 19+i, and the bit stays set. The mapping is: ack 0, stuff 1, CRC 2, stuck-dominant 3, bit 4, form 5.
- R4: Writing 1 to a status bit in 24..19 clears it, and a pulse in the same cycle wins over the clear. Writes to bits 18..16 and 1..0 have no effect.
- R5: Status bit 0 is set when tx_err_cnt >= rx_err_cnt, and bit 1 is set when rx_err_cnt >= tx_err_cnt.
- R6: On an upward move into warning, passive or bus-off, interrupt flag bit 8, 9 or 10 respectively is set. This happens in the same cycle as the status change. A downward move sets no flag.
- R7: An interrupt flag stays set until 1 is written to it at address 1. A new setting event in the same cycle wins over the clear.
- R8: The mask register keeps only bits 10..8 and ignores all other bits. irq is the OR of the flags ANDed with the mask, registered one cycle later.
- R9: reg_rdata shows the register addressed in the previous cycle. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_cnt | input | CNT_W | Transmit error counter value |
| rx_err_cnt | input | CNT_W | Receive error counter value |
| err_evt | input | 6 | Single-cycle error-kind pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong stored level shows up in status bits 18..16 at the next read. Because flags are set by comparing the new level with the stored one, a wrong level also appears as a missing or extra flag bit within one cycle of the counter change. A stuck flag or mask bit shows on irq two cycles after the stimulus. The bench sweeps counter pairs around every threshold from a known starting level, and walks each counter over its full range, so that any threshold or override error shows up as a mismatch on the first affected value.

// File: rtl/cet_pkg.sv
package cet_pkg;
  localparam int N_EVT = 6;
  localparam int N_LVL = 3;
  localparam int ST_SIDE_LSB = 0;
  localparam int ST_LVL_LSB  = 16;
  localparam int ST_EVT_LSB  = 19;
  localparam int IF_LSB      = 8;
  localparam int A_STATUS = 0;
  localparam int A_IFLAG  = 1;
  localparam int A_IMASK  = 2;
  localparam logic [N_LVL-1:0] IMASK_RST = '1;

  typedef enum logic [1:0] {
    LV_ACTIVE  = 2'd0,
    LV_WARN    = 2'd1,
    LV_PASSIVE = 2'd2,
    LV_BUSOFF  = 2'd3
  } fc_level_e;
endpackage

// File: rtl/cet_level_eval.sv
module cet_level_eval import cet_pkg::*; #(
  parameter int CNT_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  output logic [N_LVL-1:0] lvl_bits,
  output logic [1:0]       side_q,
  output logic [N_LVL-1:0] rise
);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIM);
  localparam logic [CNT_W-1:0] BOFF_V = CNT_W'(BOFF_LIM);

  fc_level_e lvl_q, lvl_d;

  // Bus-off has priority over passive, passive over warning.
  always_comb begin
    if (tx_cnt > BOFF_V)
      lvl_d = LV_BUSOFF;
    else if (tx_cnt >= PASS_V || rx_cnt >= PASS_V)
      lvl_d = LV_PASSIVE;
    else if (tx_cnt >= WARN_V || rx_cnt >= WARN_V)
      lvl_d = LV_WARN;
    else
      lvl_d = LV_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= LV_ACTIVE;
      side_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      side_q <= {rx_cnt >= tx_cnt, tx_cnt >= rx_cnt};
    end
  end

  // One status bit and one upward-move pulse per non-active level.
  for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
    assign lvl_bits[k] = (lvl_q == 2'(k + 1));
    assign rise[k]     = (lvl_d == 2'(k + 1)) && (lvl_d > lvl_q);
  end
endmodule

// File: rtl/cet_sticky_bank.sv
module cet_sticky_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  // Set has priority over write-one-to-clear.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_d[i] = set_i[i] | (q[i] & ~clr_i[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_d;
  end
endmodule

// File: rtl/cet_irq_gate.sv
module cet_irq_gate import cet_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic [N_LVL-1:0] mask_wdata,
  input  logic [N_LVL-1:0] flags,
  output logic [N_LVL-1:0] mask_q,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= IMASK_RST;
      irq    <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      irq <= |(flags & mask_q);
    end
  end
endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker import cet_pkg::*; #(
  parameter int CNT_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 255,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  input  logic [N_EVT-1:0]  err_evt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [N_LVL-1:0] lvl_bits, rise, iflag_q, mask_q;
  logic [1:0]       side_q;
  logic [N_EVT-1:0] err_q;
  logic             wr_status, wr_iflag, wr_imask;
  logic [DATA_W-1:0] status_w, rd_mux;

  assign wr_status = reg_we && (reg_addr == ADDR_W'(A_STATUS));
  assign wr_iflag  = reg_we && (reg_addr == ADDR_W'(A_IFLAG));
  assign wr_imask  = reg_we && (reg_addr == ADDR_W'(A_IMASK));

  cet_level_eval #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM)
  ) u_level (
    .clk(clk), .rst(rst), .tx_cnt(tx_err_cnt), .rx_cnt(rx_err_cnt),
    .lvl_bits(lvl_bits), .side_q(side_q), .rise(rise)
  );

  cet_sticky_bank #(.W(N_EVT)) u_err_flags (
    .clk(clk), .rst(rst), .set_i(err_evt),
    .clr_i(wr_status ? reg_wdata[ST_EVT_LSB +: N_EVT] : '0),
    .q(err_q)
  );

  cet_sticky_bank #(.W(N_LVL)) u_int_flags (
    .clk(clk), .rst(rst), .set_i(rise),
    .clr_i(wr_iflag ? reg_wdata[IF_LSB +: N_LVL] : '0),
    .q(iflag_q)
  );

  cet_irq_gate u_irq (
    .clk(clk), .rst(rst), .mask_we(wr_imask),
    .mask_wdata(reg_wdata[IF_LSB +: N_LVL]), .flags(iflag_q),
    .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    status_w = '0;
    status_w[ST_SIDE_LSB +: 2]    = side_q;
    status_w[ST_LVL_LSB +: N_LVL] = lvl_bits;
    status_w[ST_EVT_LSB +: N_EVT] = err_q;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(A_STATUS): rd_mux = status_w;
      ADDR_W'(A_IFLAG):  rd_mux[IF_LSB +: N_LVL] = iflag_q;
      ADDR_W'(A_IMASK):  rd_mux[IF_LSB +: N_LVL] = mask_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/can_fault_tracker_chk.sv
module can_fault_tracker_chk import cet_pkg::*; #(
  parameter int CNT_W    = 9,
  parameter int BOFF_LIM = 255,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  tx_err_cnt,
  input logic [N_EVT-1:0]  err_evt,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic [N_LVL-1:0]  lvl_bits,
  input logic [N_EVT-1:0]  err_q,
  input logic [N_LVL-1:0]  iflag_q,
  input logic [N_LVL-1:0]  mask_q
);
  localparam logic [CNT_W-1:0] BOFF_V = CNT_W'(BOFF_LIM);
  logic [N_LVL-1:0] if_clr;
  assign if_clr = (reg_we && reg_addr == ADDR_W'(A_IFLAG)) ? reg_wdata[IF_LSB +: N_LVL] : '0;

  // R2
  lvl_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(lvl_bits));
  // R2
  busoff_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_err_cnt > BOFF_V) |=> lvl_bits[2]);
  // R3
  evt_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (|err_evt) |=> ((err_q & $past(err_evt)) == $past(err_evt)));
  // R7
  iflag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|iflag_q) |=> (($past(iflag_q) & ~$past(if_clr) & ~iflag_q) == '0));
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (|(iflag_q & mask_q)) |=> irq);
endmodule

bind can_fault_tracker can_fault_tracker_chk #(
  .CNT_W(CNT_W), .BOFF_LIM(BOFF_LIM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .tx_err_cnt(tx_err_cnt), .err_evt(err_evt),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
  .lvl_bits(lvl_bits), .err_q(err_q), .iflag_q(iflag_q), .mask_q(mask_q)
);

// File: tb/can_fault_tracker_bench.sv
`timescale 1ns/1ps
module can_fault_tracker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  tec = '0, rec = '0;
  logic [5:0]  evt = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  can_fault_tracker u_can_fault_tracker (
    .clk(clk), .rst(rst), .tx_err_cnt(tec), .rx_err_cnt(rec), .err_evt(evt),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk) addr = a;
    @(negedge clk) v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk) begin we = 1'b1; addr = a; wdata = d; end
    @(negedge clk) we = 1'b0;
  endtask

  task automatic set_cnt(input int t, input int r);
    @(negedge clk) begin tec = 9'(t); rec = 9'(r); end
  endtask

  function automatic int rank(input int t, input int r);
    if (t > 255) return 3;
    if (t >= 128 || r >= 128) return 2;
    if (t >= 96 || r >= 96) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_st(input int t, input int r);
    logic [31:0] v = '0;
    int k = rank(t, r);
    if (k > 0) v[15 + k] = 1'b1;
    v[0] = (t >= r);
    v[1] = (r >= t);
    return v;
  endfunction

  initial begin : wdog
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int vals[9] = '{0, 95, 96, 127, 128, 200, 255, 256, 511};
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 0);
    chk("R1 irq in reset", {31'b0, irq}, 0);
    @(negedge clk) rst = 1'b0;
    rd(1, v); chk("R1 flags after reset", v, 0);
    rd(2, v); chk("R1 mask after reset", v, 32'h700);
    rd(0, v); chk("R2 R5 status idle", v, exp_st(0, 0));
    rd(3, v); chk("R9 unused address", v, 0);

    // Grid sweep from the active level: R2 R5 R6 R8
    foreach (vals[i]) foreach (vals[j]) begin
      set_cnt(0, 0);
      wr(1, 32'h700);
      set_cnt(vals[i], vals[j]);
      rd(0, v); chk("R2 R5 status grid", v, exp_st(vals[i], vals[j]));
      rd(1, v);
      chk("R6 upward flag grid", v,
          rank(vals[i], vals[j]) > 0 ? (32'h1 << (7 + rank(vals[i], vals[j]))) : 0);
      chk("R8 irq grid", {31'b0, irq}, {31'b0, v != 0});
    end

    // Full walks of each counter: R2 R6
    set_cnt(0, 0); wr(1, 32'h700);
    for (int t = 0; t < 512; t++) begin
      set_cnt(t, 0);
      rd(0, v); chk("R2 tx walk", v, exp_st(t, 0));
    end
    rd(1, v); chk("R6 tx walk flags", v, 32'h700);
    set_cnt(0, 0); wr(1, 32'h700);
    for (int r = 0; r < 512; r++) begin
      set_cnt(0, r);
      rd(0, v); chk("R2 rx walk", v, exp_st(0, r));
    end
    rd(1, v); chk("R6 rx walk flags", v, 32'h300);

    // Downward moves set nothing: R6
    set_cnt(300, 0); wr(1, 32'h700);
    set_cnt(130, 0); set_cnt(100, 0); set_cnt(0, 0);
    rd(1, v); chk("R6 downward no flag", v, 0);
    set_cnt(100, 0); wr(1, 32'h700);
    set_cnt(130, 0);
    rd(1, v); chk("R6 warn to passive", v, 32'h200);

    // Sticky error kinds: R3 R4
    set_cnt(0, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) evt = 6'(1 << i);
      @(negedge clk) evt = '0;
      rd(0, v); chk("R3 sticky event", v, (32'h1 << (19 + i)) | 32'h3);
      wr(0, 32'h1 << (19 + i));
      rd(0, v); chk("R4 w1c event", v, 32'h3);
    end
    @(negedge clk) evt = '1;
    @(negedge clk) evt = '0;
    wr(0, 32'h0007_0003);
    rd(0, v); chk("R4 readonly bits ignore write", v, 32'h01F8_0003);
    wr(0, 32'h01F8_0000);
    @(negedge clk) begin evt = 6'h01; we = 1'b1; addr = 2'd0; wdata = 32'h0008_0000; end
    @(negedge clk) begin evt = '0; we = 1'b0; end
    rd(0, v); chk("R4 event wins over clear", v, 32'h0008_0003);

    // Flag hold and set priority: R7
    wr(1, 32'h700);
    @(negedge clk) begin tec = 9'd100; we = 1'b1; addr = 2'd1; wdata = 32'h100; end
    @(negedge clk) we = 1'b0;
    rd(1, v); chk("R7 set wins over clear", v, 32'h100);
    repeat (5) @(negedge clk);
    rd(1, v); chk("R7 flag held", v, 32'h100);

    // Mask: R8
    wr(2, 32'h0);
    rd(2, v); chk("R8 mask cleared", v, 0);
    chk("R8 irq masked", {31'b0, irq}, 0);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); chk("R8 mask only 10:8", v, 32'h700);
    chk("R8 irq unmasked", {31'b0, irq}, 1);
    wr(2, 32'h200);
    rd(2, v);
    chk("R8 irq other bit masked", {31'b0, irq}, 0);
    wr(1, 32'h100);
    rd(1, v); chk("R7 w1c flag", v, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule